// File: doc/BRIEF.md
# Glitch-free half-rate clock switch

This block produces one clock that runs either at the full rate or at half of it. A low-power request picks the rate. The request may change at any time, with no relation to the clock. The block passes it through a synchronizer. It applies the new rate only at a point in the cycle where both the full-rate and the half-rate clock are low. The output pulse in flight is therefore lengthened or shortened, and never cut. A status bit goes high when the half-rate clock is the one being driven.

The block is a digital model. It runs from `clk_src_i`, which ticks at twice the full output rate. A two-bit phase counter holds both candidate clocks: bit 0 is the full-rate clock, with a period of 2 ticks, and bit 1 is the half-rate clock, with a period of 4 ticks. Both are low when the counter is zero. The output clock is taken from a register, so the rate choice never reaches the pin as a combinational mux.

Top module: `hr_clock_switch`

## Requirements
- R1: While `rst_ni` is low, `clk_o` and `half_rate_o` are 0, and the divider counter is cleared. After release the block starts at full rate, and `clk_o` goes to 1 on the first `clk_src_i` edge.
- R2: While `half_rate_o` stays 0, `clk_o` changes level on every `clk_src_i` edge. Each high phase and each low phase lasts one tick.
- R3: While `half_rate_o` stays 1, every high phase and every low phase of `clk_o` lasts exactly two ticks.
- R4: `half_rate_o` changes only at an edge where `clk_o` falls from 1 to 0. That is the point where both candidate clocks are low. The new value equals `pd_req_i` as sampled SYNC_STAGES+1 edges before.
- R5: When half rate is entered, the low phase that starts at that edge lasts two ticks. The pulse in flight is stretched.
- R6: When full rate is resumed, the high phase just before the switch lasts two ticks. The low phase that starts at the switch lasts one tick, and so does every later phase.
- R7: No phase of `clk_o` is ever shorter than one tick or longer than two ticks. This holds even when `pd_req_i` toggles every few ticks.
- R8: After a stable change of `pd_req_i`, `half_rate_o` follows within SYNC_STAGES+1 to SYNC_STAGES+4 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source tick, twice the full output rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Asynchronous request for half rate (1 = half rate) |
| clk_o | output | 1 | Selected output clock, registered |
| half_rate_o | output | 1 | 1 while the half-rate clock is being driven |

## Verification
The hard case is a request that changes again before its earlier value has passed the synchronizer and reached a phase boundary. A mid-pulse cut could only happen there. A dedicated task toggles `pd_req_i` with hold times of one to five ticks that keep shifting against the four-tick phase counter, so the request edges fall on every counter phase. A monitor running in the background measures every phase of `clk_o` during that run. A second case asserts reset while the block is at half rate and the request is still high. This shows that reset forces full rate, and that the block then re-enters half rate through the normal path.

// File: rtl/hr_clk_pkg.sv
package hr_clk_pkg;
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;

  // counter width: bit 0 is the full-rate clock, the top bit the half-rate clock
  localparam int unsigned PHASE_W = 2;
endpackage

// File: rtl/hr_req_sync.sv
module hr_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hr_phase_gen.sv
module hr_phase_gen
  import hr_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_nxt_o,   // full-rate clock after this edge
  output logic slow_nxt_o,   // half-rate clock after this edge
  output logic both_low_o    // both candidates will be low after this edge
);
  logic [PHASE_W-1:0] cnt_q;
  logic [PHASE_W-1:0] cnt_d;

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign fast_nxt_o = cnt_d[0];
  assign slow_nxt_o = cnt_d[PHASE_W-1];
  assign both_low_o = (cnt_d == '0);
endmodule

// File: rtl/hr_rate_ctl.sv
module hr_rate_ctl
  import hr_clk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_sync_i,
  input  logic  both_low_i,
  input  logic  fast_nxt_i,
  input  logic  slow_nxt_i,
  output logic  clk_q_o,
  output rate_e rate_o
);
  rate_e mode_q, mode_d;
  logic  out_q, out_d;

  // the mode may only change where both candidates start a low phase together
  always_comb begin
    mode_d = mode_q;
    if (both_low_i) mode_d = rate_e'(req_sync_i);
  end

  assign out_d = (mode_d == RATE_HALF) ? slow_nxt_i : fast_nxt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RATE_FULL;
      out_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      out_q  <= out_d;
    end
  end

  assign clk_q_o = out_q;
  assign rate_o  = mode_q;
endmodule

// File: rtl/hr_clock_switch.sv
module hr_clock_switch
  import hr_clk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  output logic clk_o,
  output logic half_rate_o
);
  logic  req_sync;
  logic  fast_nxt, slow_nxt, both_low;
  rate_e rate;

  hr_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_src_i),
    .rst_ni(rst_ni),
    .d_i   (pd_req_i),
    .q_o   (req_sync)
  );

  hr_phase_gen u_phase (
    .clk_i     (clk_src_i),
    .rst_ni    (rst_ni),
    .fast_nxt_o(fast_nxt),
    .slow_nxt_o(slow_nxt),
    .both_low_o(both_low)
  );

  hr_rate_ctl u_ctl (
    .clk_i     (clk_src_i),
    .rst_ni    (rst_ni),
    .req_sync_i(req_sync),
    .both_low_i(both_low),
    .fast_nxt_i(fast_nxt),
    .slow_nxt_i(slow_nxt),
    .clk_q_o   (clk_o),
    .rate_o    (rate)
  );

  assign half_rate_o = (rate == RATE_HALF);
endmodule

// File: rtl/hr_clock_switch_chk.sv
module hr_clock_switch_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_src_i,
  input logic rst_ni,
  input logic pd_req_i,
  input logic clk_o,
  input logic half_rate_o
);
  logic [2:0] age_q;
  logic [1:0] run_q;
  logic       last_clk_q, last_rate_q;
  logic       armed, toggled, rate_moved;

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q       <= '0;
      run_q       <= 2'd1;
      last_clk_q  <= 1'b0;
      last_rate_q <= 1'b0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      last_clk_q  <= clk_o;
      last_rate_q <= half_rate_o;
      if (clk_o != last_clk_q) run_q <= 2'd1;
      else if (run_q != 2'd3)  run_q <= run_q + 2'd1;
    end
  end

  assign armed      = (age_q > 3'(SYNC_STAGES + 1));
  assign toggled    = (clk_o != last_clk_q);
  assign rate_moved = (half_rate_o != last_rate_q);

  // R1: reset holds the output clock and the status low
  p_reset_quiet_r1: assert property (@(posedge clk_src_i)
    !rst_ni |=> (!clk_o && !half_rate_o));

  // R2: at steady full rate the output changes level on every tick
  p_full_toggle_r2: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    (armed && !half_rate_o && !last_rate_q && !$past(last_rate_q)) |-> toggled);

  // R3: at steady half rate each completed phase lasted two ticks
  p_half_phase_r3: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    (armed && toggled && half_rate_o && last_rate_q) |-> (run_q == 2'd2));

  // R4: the rate changes only where the output falls, and only to the synchronized request
  p_switch_on_fall_r4: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    (armed && rate_moved) |-> (!clk_o && last_clk_q &&
                               half_rate_o == $past(pd_req_i, SYNC_STAGES + 1)));

  // R7: no phase shorter than one tick or longer than two
  p_no_runt_r7: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    armed |-> (run_q <= 2'd2));
endmodule

bind hr_clock_switch hr_clock_switch_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_src_i  (clk_src_i),
  .rst_ni     (rst_ni),
  .pd_req_i   (pd_req_i),
  .clk_o      (clk_o),
  .half_rate_o(half_rate_o)
);

// File: tb/tb_hr_clock_switch.sv
module tb_hr_clock_switch;
  localparam int unsigned SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic clk_o, half_rate_o;

  int checks = 0;
  int errors = 0;
  int phase_err = 0;
  bit done = 1'b0;

  hr_clock_switch #(.SYNC_STAGES(SYNC)) dut (
    .clk_src_i  (clk),
    .rst_ni     (rst_n),
    .pd_req_i   (req),
    .clk_o      (clk_o),
    .half_rate_o(half_rate_o)
  );

  always #5 clk = ~clk;

  // background phase monitor (R7)
  logic mon_prev = 1'b0;
  int   mon_run = 0;
  bit   mon_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_prev  = 1'b0;
      mon_run   = 0;
      mon_valid = 1'b0;
    end else if (clk_o != mon_prev) begin
      if (mon_valid && (mon_run < 1 || mon_run > 2)) phase_err++;
      mon_valid = 1'b1;
      mon_run   = 1;
      mon_prev  = clk_o;
    end else begin
      mon_run++;
      if (mon_valid && mon_run > 2) phase_err++;
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // ticks until the level seen now changes; from the first sample of a phase this is its length
  task automatic phase_len(output int len);
    logic p;
    p   = clk_o;
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (clk_o == p && len < 20);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req   = 1'b0;
    repeat (3) @(negedge clk);
    check(clk_o == 1'b0, "R1 clk_o in reset", clk_o, 0);
    check(half_rate_o == 1'b0, "R1 status in reset", half_rate_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_o == 1'b1, "R1 first rise after release", clk_o, 1);
    check(half_rate_o == 1'b0, "R1 full rate after release", half_rate_o, 0);
  endtask

  task automatic t_full_steady();
    int len;
    phase_len(len);
    for (int i = 0; i < 8; i++) begin
      phase_len(len);
      check(len == 1, "R2 full-rate phase", len, 1);
    end
  endtask

  task automatic t_enter_half();
    int n, len;
    logic prev;
    n = 0;
    req = 1'b1;
    do begin
      prev = clk_o;
      @(negedge clk);
      n++;
    end while (!half_rate_o && n < 20);
    check(n >= SYNC + 1 && n <= SYNC + 4, "R8 entry latency", n, SYNC + 1);
    check(clk_o == 1'b0 && prev == 1'b1, "R4 entry on falling edge", {prev, clk_o}, 2);
    len = 1;
    forever begin
      @(negedge clk);
      if (clk_o == 1'b0) len++;
      else break;
    end
    check(len == 2, "R5 stretched low phase", len, 2);
    for (int i = 0; i < 8; i++) begin
      phase_len(len);
      check(len == 2, "R3 half-rate phase", len, 2);
    end
  endtask

  task automatic t_leave_half();
    int n, run, last, len;
    logic prev;
    n    = 0;
    run  = 1;
    last = 0;
    req  = 1'b0;
    do begin
      prev = clk_o;
      @(negedge clk);
      n++;
      if (clk_o == prev) run++;
      else begin
        last = run;
        run  = 1;
      end
    end while (half_rate_o && n < 20);
    check(n >= SYNC + 1 && n <= SYNC + 4, "R8 exit latency", n, SYNC + 1);
    check(clk_o == 1'b0 && prev == 1'b1, "R4 exit on falling edge", {prev, clk_o}, 2);
    check(last == 2, "R6 high phase before exit", last, 2);
    phase_len(len);
    check(len == 1, "R6 shrunk low phase", len, 1);
    for (int i = 0; i < 6; i++) begin
      phase_len(len);
      check(len == 1, "R6 later full-rate phase", len, 1);
    end
  endtask

  task automatic t_glitchy_request();
    int snap;
    snap = phase_err;
    for (int i = 0; i < 40; i++) begin
      req = ~req;
      repeat (1 + (i % 5)) @(negedge clk);
    end
    req = 1'b0;
    repeat (12) @(negedge clk);
    check(phase_err == snap, "R7 phases under toggling request", phase_err - snap, 0);
    check(half_rate_o == 1'b0, "R8 settles to full rate", half_rate_o, 0);
    t_full_steady();
  endtask

  task automatic t_reset_in_half();
    req = 1'b1;
    repeat (12) @(negedge clk);
    check(half_rate_o == 1'b1, "R8 half rate before reset", half_rate_o, 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(clk_o == 1'b0 && half_rate_o == 1'b0, "R1 reset from half rate",
          {clk_o, half_rate_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(half_rate_o == 1'b0 && clk_o == 1'b1, "R1 restart at full rate",
          {half_rate_o, clk_o}, 1);
    repeat (SYNC + 5) @(negedge clk);
    check(half_rate_o == 1'b1, "R8 re-entry after reset", half_rate_o, 1);
    req = 1'b0;
    repeat (12) @(negedge clk);
    check(phase_err == 0, "R7 no bad phase overall", phase_err, 0);
  endtask

  initial begin
    t_reset();
    t_full_steady();
    t_enter_half();
    t_leave_half();
    t_enter_half();
    t_leave_half();
    t_glitchy_request();
    t_reset_in_half();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule